// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This block sits between a memory controller's active-low chip-enable and an external static RAM. An analog comparator outside the block turns the supply state into two digital fault flags: one trips at a tight tolerance of about 5%, the other at a loose tolerance of about 10%. A select pin chooses which of the two the gate obeys. While the supply is good, the raw enable reaches the memory with no clocked delay. When the chosen flag reports a fault, the gate write-protects the memory by holding its conditioned enable high.

An access that is already running when the fault arrives may finish, but only within a bounded window counted in clock cycles. After the supply returns, the gate keeps the memory locked out for a recovery period before it lets the enable through again. That period is nominally about 80 ms and at most 120 ms, and it is set as a cycle count.

The fault flags are asynchronous to the clock. They pass through a synchronizer of `SYNC_STAGES` flops that resets to the fault level. All cycle counts below measure edges from the first rising clock edge at which the selected flag input holds its new level.

The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control level.

Top module: `pf_ce_gate`

## Requirements
- R1: While `rst_n` is low the conditioned enable `ce_gated_n` is 1, whatever `ce_raw_n` does. Reset leaves the gate in the protected state.
- R2: The selected fault flag may fall, or reset may be released with the selected flag low. In either case `ce_gated_n` stays 1 through edge SYNC_STAGES+RECOV_CYC and follows `ce_raw_n` from edge SYNC_STAGES+1+RECOV_CYC onward.
- R3: In the passing state, `ce_gated_n` equals `ce_raw_n` combinationally, in the same cycle, for every input pattern.
- R4: The selected flag may rise while `ce_raw_n` is 1. From edge SYNC_STAGES+1 onward, `ce_gated_n` is then 1 whatever `ce_raw_n` does.
- R5: The selected flag may rise while `ce_raw_n` is 0, which is an access in flight. `ce_gated_n` then stays 0 until `ce_raw_n` returns to 1. From then on it is 1, even if `ce_raw_n` falls again while the fault lasts.
- R6: An access that is still running WRITE_PROT_CYC cycles after the drain starts at edge SYNC_STAGES+1 is cut off. `ce_gated_n` is 0 after edge SYNC_STAGES+WRITE_PROT_CYC and is forced to 1 after edge SYNC_STAGES+1+WRITE_PROT_CYC.
- R7: A fault seen during the recovery count sends the gate back to the protected state. After the flag clears again, a full recovery count of R2 runs, and the enable is never released early.
- R8: `tol_sel` = 0 makes the gate obey `fault_tight` (the 5% detector) and ignore `fault_loose`. `tol_sel` = 1 makes it obey `fault_loose` (the 10% detector) and ignore `fault_tight`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_raw_n | input | 1 | Unconditioned chip-enable from the controller, active low |
| fault_tight | input | 1 | Fault flag from the 5% detector, 1 = supply out of tolerance |
| fault_loose | input | 1 | Fault flag from the 10% detector, 1 = supply out of tolerance |
| tol_sel | input | 1 | Detector select: 0 obeys fault_tight, 1 obeys fault_loose |
| ce_gated_n | output | 1 | Conditioned chip-enable to the memory, active low |

## Verification
The bench measures the recovery and drain windows to the exact edge. An off-by-one counter would release the memory one cycle early or late, or cut an access one cycle off, and a check would see it. It ends an access during a drain and then lowers the raw enable again: a gate that returned to passing would let a write through during the fault. It pulses a fault in the middle of the recovery count, and a gate that only paused its count would release early. It also drives the unselected detector and lets the selected one clear while the other stays high: a crossed select would lock the memory out or leave it writable at the wrong threshold.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    ST_PROT  = 2'd0,  // write-protected, waiting for a good supply
    ST_RECOV = 2'd1,  // supply good, lockout count running
    ST_PASS  = 2'd2,  // enable passes through
    ST_DRAIN = 2'd3   // fault seen, running access allowed to end
  } pfg_state_e;

  function automatic logic pfg_passes(input pfg_state_e s);
    return (s == ST_PASS) || (s == ST_DRAIN);
  endfunction

endpackage

// File: rtl/pfg_flag_sync.sv
module pfg_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_in,
  output logic flag_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign flag_out = flag_in;
    end else begin : g_chain
      // reset to the fault level so that a full recovery follows reset
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], flag_in} >> 0;
      end
      assign flag_out = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pfg_timer.sv
module pfg_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (dec && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
#(
  parameter int CW             = 8,
  parameter int RECOV_CYC      = 20,
  parameter int WRITE_PROT_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault,
  input  logic       ce_raw_n,
  input  logic       ce_out_n,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic       tmr_dec,
  output pfg_state_e state
);

  localparam logic [CW-1:0] RECOV_LOAD = CW'(RECOV_CYC - 1);
  localparam logic [CW-1:0] DRAIN_LOAD = CW'(WRITE_PROT_CYC - 1);

  pfg_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = RECOV_LOAD;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_PROT: begin
        if (!fault) begin
          state_d  = ST_RECOV;
          tmr_load = 1'b1;
          tmr_val  = RECOV_LOAD;
        end
      end
      ST_RECOV: begin
        if (fault)         state_d = ST_PROT;
        else if (tmr_zero) state_d = ST_PASS;
        else               tmr_dec = 1'b1;
      end
      ST_PASS: begin
        if (fault) begin
          if (!ce_raw_n) begin
            state_d  = ST_DRAIN;
            tmr_load = 1'b1;
            tmr_val  = DRAIN_LOAD;
          end else begin
            state_d  = ST_PROT;
          end
        end
      end
      ST_DRAIN: begin
        if (ce_raw_n || tmr_zero) state_d = ST_PROT;
        else                      tmr_dec = 1'b1;
      end
      default: state_d = ST_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PROT;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // drain length observer for the timeout property
  logic [CW-1:0] drain_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  drain_len_q <= '0;
    else if (state_q == ST_DRAIN) drain_len_q <= drain_len_q + 1'b1;
    else                         drain_len_q <= '0;
  end

  a_r6_drain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (drain_len_q < CW'(WRITE_PROT_CYC)));

  a_r5_drain_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PASS && fault && !ce_raw_n) |=> (state_q == ST_DRAIN));

  a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && ce_raw_n) |=> ce_out_n);

  a_r7_fault_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV && fault) |=> (state_q == ST_PROT));

  a_r2_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_PASS) |-> ($past(state_q) == ST_RECOV && $past(tmr_zero)));

endmodule

// File: rtl/pf_ce_gate.sv
module pf_ce_gate
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int RECOV_CYC      = 16000000,
  parameter int WRITE_PROT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_raw_n,
  input  logic fault_tight,
  input  logic fault_loose,
  input  logic tol_sel,
  output logic ce_gated_n
);

  localparam int MAXCYC = (RECOV_CYC > WRITE_PROT_CYC) ? RECOV_CYC : WRITE_PROT_CYC;
  localparam int CW     = $clog2(MAXCYC + 1);

  logic          flag_sel;
  logic          fault_s;
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0] tmr_val;
  pfg_state_e    state;

  assign flag_sel = tol_sel ? fault_loose : fault_tight;

  pfg_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_in  (flag_sel),
    .flag_out (fault_s)
  );

  pfg_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  pfg_ctrl #(
    .CW             (CW),
    .RECOV_CYC      (RECOV_CYC),
    .WRITE_PROT_CYC (WRITE_PROT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault    (fault_s),
    .ce_raw_n (ce_raw_n),
    .ce_out_n (ce_gated_n),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_dec  (tmr_dec),
    .state    (state)
  );

  assign ce_gated_n = pfg_passes(state) ? ce_raw_n : 1'b1;

  always_comb begin
    if (!rst_n) a_r1_reset_protects: assert (ce_gated_n);
  end

endmodule

// File: tb/tb_pf_ce_gate.sv
`timescale 1ns/1ps
module tb_pf_ce_gate;

  localparam int S   = 2;
  localparam int RC  = 20;
  localparam int WPT = 8;

  logic clk = 1'b0;
  logic rst_n, ce_raw_n, fault_tight, fault_loose, tol_sel;
  logic ce_gated_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pf_ce_gate #(.SYNC_STAGES(S), .RECOV_CYC(RC), .WRITE_PROT_CYC(WPT)) dut (
    .clk(clk), .rst_n(rst_n), .ce_raw_n(ce_raw_n), .fault_tight(fault_tight),
    .fault_loose(fault_loose), .tol_sel(tol_sel), .ce_gated_n(ce_gated_n)
  );

  // {raw enable, expected conditioned enable} in the passing state
  localparam logic [1:0] PT_VEC [8] = '{2'b00, 2'b11, 2'b00, 2'b00,
                                        2'b11, 2'b11, 2'b00, 2'b11};

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ce_gated_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_raw_n = 0; fault_tight = 0; fault_loose = 0; tol_sel = 0;
    @(negedge clk); #1;
    chk("R1 reset", ce_gated_n, 1'b1);
    ce_raw_n = 1; #1;
    chk("R1 reset", ce_gated_n, 1'b1);
    ce_raw_n = 0;
    @(negedge clk);
    rst_n = 1;
    // R2: recovery after reset
    edges(S + RC);
    chk("R2 still locked", ce_gated_n, 1'b1);
    edges(1);
    chk("R2 released", ce_gated_n, 1'b0);

    // R3: table of pass-through patterns
    for (int i = 0; i < 8; i++) begin
      ce_raw_n = PT_VEC[i][1];
      #1;
      chk("R3 pass-through", ce_gated_n, PT_VEC[i][0]);
      @(negedge clk);
    end

    // R4: fault with no access
    ce_raw_n = 1; fault_tight = 1;
    edges(S + 1);
    ce_raw_n = 0; #1;
    chk("R4 fault protects", ce_gated_n, 1'b1);
    edges(2);
    chk("R4 fault protects", ce_gated_n, 1'b1);

    // R2 again after fault clears
    @(negedge clk);
    fault_tight = 0;
    edges(S + RC);
    chk("R2 still locked", ce_gated_n, 1'b1);
    edges(1);
    chk("R2 released", ce_gated_n, 1'b0);

    // R5: access in flight finishes
    fault_tight = 1;
    edges(S + 1);
    chk("R5 access continues", ce_gated_n, 1'b0);
    edges(3);
    chk("R5 access continues", ce_gated_n, 1'b0);
    ce_raw_n = 1; #1;
    chk("R5 access ended", ce_gated_n, 1'b1);
    edges(1);
    ce_raw_n = 0; #1;
    chk("R5 stays protected", ce_gated_n, 1'b1);

    // R6: timeout of an access that does not end
    @(negedge clk);
    fault_tight = 0;
    edges(S + 1 + RC);
    chk("R2 released", ce_gated_n, 1'b0);
    fault_tight = 1;
    edges(S + 1);
    edges(WPT - 1);
    chk("R6 before timeout", ce_gated_n, 1'b0);
    edges(1);
    chk("R6 timeout cut", ce_gated_n, 1'b1);

    // R7: fault pulse during recovery restarts the count
    fault_tight = 0;
    edges(S + 1 + RC / 2);
    fault_tight = 1;
    edges(1);
    fault_tight = 0;
    edges(RC + 2);
    chk("R7 no early release", ce_gated_n, 1'b1);
    edges(1);
    chk("R7 full recovery", ce_gated_n, 1'b0);

    // R8: detector select
    fault_loose = 1;
    edges(S + 3);
    chk("R8 loose ignored", ce_gated_n, 1'b0);
    ce_raw_n = 1; tol_sel = 1;
    edges(S + 1);
    ce_raw_n = 0; #1;
    chk("R8 loose obeyed", ce_gated_n, 1'b1);
    @(negedge clk);
    fault_tight = 1; fault_loose = 0;
    edges(S + RC);
    chk("R8 tight ignored", ce_gated_n, 1'b1);
    edges(1);
    chk("R8 tight ignored", ce_gated_n, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule